// File: doc/BRIEF.md
# UART Register Front End with Data-Word Handshake

This block is the register-facing half of a simple 8N1 UART. It decodes a small word-aligned register window on a 32-bit read/write bus and turns bus accesses into a byte hand-off to a transmit serializer. It also captures bytes that a receive deserializer delivers. Both handshake flags live in the data word. Software checks the transmit-ready flag, then writes the byte with that flag bit set to launch it. It polls the receive-valid flag, reads the byte, and acknowledges it by writing back a word with only the receive flag bit set.

Two more registers sit beside the data word. A control word holds a two-bit interface-mode field and two ready-override bits, which are brought out as plain outputs for the flow-control logic. A clock word holds a scale and a step value that drive a separate baud-rate generator. The serializer, baud generator, interrupts, DMA and flow control are outside this block.

Top module: `uart_csr_front`

## Requirements
- R1: Registers decode at byte offsets 0x00 (data), 0x04 (control) and 0x08 (clock). The remaining words of the 0x14-byte window (0x0C and 0x10) read 0, and writes to them change no register.
- R2: After reset, the data word reads 0x200 (transmit-ready 1, receive-valid 0, byte 0), the control and clock words read 0, rx_overrun is 0 and tx_load is 0.
- R3: A data write with bit 9 set while transmit-ready is 1 pulses tx_load for exactly one cycle, in the cycle after the write, with tx_byte equal to write bits [7:0]. Transmit-ready then reads 0.
- R4: While transmit-ready is 0, a data write with bit 9 set is ignored and no load occurs. A one-cycle tx_done pulse sets transmit-ready back to 1.
- R5: A one-cycle rx_strobe with no byte waiting stores rx_byte. The data word then reads bit 8 = 1 and bits [7:0] = that byte.
- R6: A data write with bit 8 set clears receive-valid and rx_overrun. The last received byte stays readable in bits [7:0].
- R7: A data write with bits 9 and 8 both clear changes neither flag nor rx_overrun.
- R8: An rx_strobe while receive-valid is 1 and no acknowledge is written keeps the old byte and sets rx_overrun. An acknowledge written in the same cycle as an rx_strobe leaves receive-valid at 1 with the new byte, and rx_overrun at 0.
- R9: Control bits [3:2] hold the interface mode (1 = DTE, 2 = DCE), bit 7 the transmit-ready override and bit 8 the receive-ready override. They appear on if_mode, tx_force and rx_force. All other control bits read 0.
- R10: Clock bits [15:0] hold the baud step and bits [27:16] the baud scale. They appear on baud_step and baud_scale, and bits [31:28] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tx_byte | output | 8 | Byte handed to the serializer |
| tx_load | output | 1 | One-cycle load pulse for tx_byte |
| tx_done | input | 1 | Serializer can take another byte (pulse) |
| rx_byte | input | 8 | Byte from the deserializer |
| rx_strobe | input | 1 | rx_byte valid (pulse) |
| rx_overrun | output | 1 | A byte was dropped while one was waiting |
| if_mode | output | 2 | Interface mode field |
| tx_force | output | 1 | Transmit-ready override |
| rx_force | output | 1 | Receive-ready override |
| baud_scale | output | SCALE_W (12) | Baud generator scale |
| baud_step | output | STEP_W (16) | Baud generator step |

## Verification
The hardest situation to reach from the ports is an acknowledge write that lands in the same clock as a new receive strobe, while an overrun is already pending. The stimulus first delivers two bytes back to back without an acknowledge, which raises the overrun. It then drives the acknowledge write and the third strobe on the same falling edge, so both arrive at one rising edge. Another hard case is a launch attempted while the transmitter is busy. The bench counts every load pulse at the falling edge and confirms that the second write produces none.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
   localparam int BYTE_W     = 8;
   localparam int BUS_W      = 32;
   // data word field positions (software decodes these)
   localparam int RXV_BIT    = 8;
   localparam int TXR_BIT    = 9;
   // control word field positions
   localparam int MODE_LSB   = 2;
   localparam int TXF_BIT    = 7;
   localparam int RXF_BIT    = 8;
   // clock word field positions
   localparam int SCALE_LSB  = 16;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_CLK  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
   import uart_csr_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int WIN_BYTES = 20
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output reg_sel_e          sel,
   output logic              wr_data,
   output logic              wr_ctrl,
   output logic              wr_clk
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   assign word = bus_addr[ADDR_W-1:2];

   always_comb begin
      sel = SEL_NONE;
      if (int'(bus_addr) < WIN_BYTES) begin
         unique case (int'(word))
            0:       sel = SEL_DATA;
            1:       sel = SEL_CTRL;
            2:       sel = SEL_CLK;
            default: sel = SEL_NONE;
         endcase
      end
   end

   assign wr_data = bus_sel && bus_wr && (sel == SEL_DATA);
   assign wr_ctrl = bus_sel && bus_wr && (sel == SEL_CTRL);
   assign wr_clk  = bus_sel && bus_wr && (sel == SEL_CLK);
endmodule

// File: rtl/uart_csr_data.sv
module uart_csr_data
   import uart_csr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              tx_done,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_strobe,
   output logic              tx_rdy,
   output logic              tx_load,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_overrun
);
   logic launch, ack;
   assign launch = wr_en && wdata[TXR_BIT] && tx_rdy;
   assign ack    = wr_en && wdata[RXV_BIT];

   // transmit side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_rdy  <= 1'b1;
         tx_load <= 1'b0;
         tx_byte <= '0;
      end else begin
         tx_load <= 1'b0;
         if (launch) begin
            tx_load <= 1'b1;
            tx_byte <= wdata[BYTE_W-1:0];
            tx_rdy  <= 1'b0;
         end else if (tx_done) begin
            tx_rdy  <= 1'b1;
         end
      end
   end

   // receive side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid   <= 1'b0;
         rx_data    <= '0;
         rx_overrun <= 1'b0;
      end else begin
         if (ack) rx_overrun <= 1'b0;
         if (rx_strobe && (ack || !rx_valid)) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_byte;
         end else if (rx_strobe) begin
            rx_overrun <= 1'b1;
         end else if (ack) begin
            rx_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/uart_csr_cfg.sv
module uart_csr_cfg
   import uart_csr_pkg::*;
#(
   parameter int SCALE_W = 12,
   parameter int STEP_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ctrl,
   input  logic               wr_clk,
   input  logic [BUS_W-1:0]   wdata,
   output logic [1:0]         if_mode,
   output logic               tx_force,
   output logic               rx_force,
   output logic [SCALE_W-1:0] baud_scale,
   output logic [STEP_W-1:0]  baud_step
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         if_mode  <= '0;
         tx_force <= 1'b0;
         rx_force <= 1'b0;
      end else if (wr_ctrl) begin
         if_mode  <= wdata[MODE_LSB +: 2];
         tx_force <= wdata[TXF_BIT];
         rx_force <= wdata[RXF_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         baud_scale <= '0;
         baud_step  <= '0;
      end else if (wr_clk) begin
         baud_scale <= wdata[SCALE_LSB +: SCALE_W];
         baud_step  <= wdata[STEP_W-1:0];
      end
   end
endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
   import uart_csr_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int WIN_BYTES = 20,
   parameter int SCALE_W   = 12,
   parameter int STEP_W    = 16,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [7:0]         tx_byte,
   output logic               tx_load,
   input  logic               tx_done,
   input  logic [7:0]         rx_byte,
   input  logic               rx_strobe,
   output logic               rx_overrun,
   output logic [1:0]         if_mode,
   output logic               tx_force,
   output logic               rx_force,
   output logic [SCALE_W-1:0] baud_scale,
   output logic [STEP_W-1:0]  baud_step
);
   // elaboration-time parameter checks
   if (STEP_W > SCALE_LSB) begin : g_bad_step
      $error("STEP_W must fit below the scale field");
   end
   if (SCALE_LSB + SCALE_W > BUS_W) begin : g_bad_scale
      $error("scale field exceeds the bus word");
   end
   if (WIN_BYTES < 12 || (1 << ADDR_W) < WIN_BYTES) begin : g_bad_win
      $error("window size and address width disagree");
   end

   reg_sel_e          sel;
   logic              wr_data, wr_ctrl, wr_clk;
   logic              tx_rdy, rx_valid;
   logic [BYTE_W-1:0] rx_data;
   logic [BUS_W-1:0]  rd_mux;

   uart_csr_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .sel(sel), .wr_data(wr_data), .wr_ctrl(wr_ctrl), .wr_clk(wr_clk)
   );

   uart_csr_data u_data (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_data), .wdata(bus_wdata),
      .tx_done(tx_done), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
      .tx_rdy(tx_rdy), .tx_load(tx_load), .tx_byte(tx_byte),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_overrun(rx_overrun)
   );

   uart_csr_cfg #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_clk(wr_clk),
      .wdata(bus_wdata), .if_mode(if_mode), .tx_force(tx_force),
      .rx_force(rx_force), .baud_scale(baud_scale), .baud_step(baud_step)
   );

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_DATA: begin
            rd_mux[BYTE_W-1:0] = rx_data;
            rd_mux[RXV_BIT]    = rx_valid;
            rd_mux[TXR_BIT]    = tx_rdy;
         end
         SEL_CTRL: begin
            rd_mux[MODE_LSB +: 2] = if_mode;
            rd_mux[TXF_BIT]       = tx_force;
            rd_mux[RXF_BIT]       = rx_force;
         end
         SEL_CLK: begin
            rd_mux[SCALE_LSB +: SCALE_W] = baud_scale;
            rd_mux[STEP_W-1:0]           = baud_step;
         end
         default: rd_mux = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bus_rdata <= '0;
         else        bus_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end
endmodule

// File: rtl/uart_csr_front_chk.sv
module uart_csr_front_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              tx_load,
   input logic              tx_done,
   input logic              rx_strobe,
   input logic              rx_overrun,
   input logic [1:0]        if_mode,
   input logic              tx_rdy,
   input logic              rx_valid,
   input logic [7:0]        rx_data
);
   logic data_wr, ack_wr, ctrl_wr;
   assign data_wr = bus_sel && bus_wr && (bus_addr == '0);
   assign ack_wr  = data_wr && bus_wdata[8];
   assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));

   // R3
   tx_load_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> !tx_rdy);

   // R4
   no_launch_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && bus_wdata[9] && !tx_rdy) |=> !tx_load);

   // R6
   ack_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !rx_strobe) |=> (!rx_valid && !rx_overrun));

   // R7
   flagless_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && bus_wdata[9:8] == 2'b00 && !rx_strobe && !tx_done)
         |=> ($stable(tx_rdy) && $stable(rx_valid) && $stable(rx_overrun)));

   // R8
   overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && rx_valid && !ack_wr) |=> ($stable(rx_data) && rx_overrun));

   // R9
   mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (if_mode == $past(bus_wdata[3:2])));
endmodule

bind uart_csr_front uart_csr_front_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_load(tx_load),
   .tx_done(tx_done), .rx_strobe(rx_strobe), .rx_overrun(rx_overrun),
   .if_mode(if_mode), .tx_rdy(tx_rdy), .rx_valid(rx_valid), .rx_data(rx_data)
);

// File: tb/uart_csr_front_test.sv
`timescale 1ns/1ps
module uart_csr_front_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  tx_byte;
   logic        tx_load;
   logic        tx_done = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_strobe = 1'b0;
   logic        rx_overrun;
   logic [1:0]  if_mode;
   logic        tx_force, rx_force;
   logic [11:0] baud_scale;
   logic [15:0] baud_step;

   int checks = 0, fails = 0;
   int loads = 0;
   logic [7:0] last_load = '0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   uart_csr_front uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_byte(tx_byte), .tx_load(tx_load), .tx_done(tx_done),
      .rx_byte(rx_byte), .rx_strobe(rx_strobe), .rx_overrun(rx_overrun),
      .if_mode(if_mode), .tx_force(tx_force), .rx_force(rx_force),
      .baud_scale(baud_scale), .baud_step(baud_step)
   );

   always @(negedge clk) if (rst_n && tx_load) begin
      loads++;
      last_load = tx_byte;
   end

   // kind: 0 write, 1 read-and-compare, 2 receive byte, 3 transmit done
   localparam int NV = 29;
   localparam logic [73:0] VEC [NV] = '{
      {2'd0, 8'h04, 32'h0000_0188, 32'h0},         // control: DCE + overrides
      {2'd1, 8'h04, 32'h0,         32'h0000_0188}, // R9
      {2'd0, 8'h04, 32'hFFFF_FFFF, 32'h0},
      {2'd1, 8'h04, 32'h0,         32'h0000_018C}, // R9 unused bits read 0
      {2'd0, 8'h08, 32'h0ABC_1234, 32'h0},
      {2'd1, 8'h08, 32'h0,         32'h0ABC_1234}, // R10
      {2'd0, 8'h08, 32'hFFFF_FFFF, 32'h0},
      {2'd1, 8'h08, 32'h0,         32'h0FFF_FFFF}, // R10 top bits read 0
      {2'd0, 8'h10, 32'hFFFF_FFFF, 32'h0},
      {2'd1, 8'h10, 32'h0,         32'h0},         // R1
      {2'd1, 8'h0C, 32'h0,         32'h0},         // R1
      {2'd1, 8'h04, 32'h0,         32'h0000_018C}, // R1 reserved write touched nothing
      {2'd0, 8'h00, 32'h0000_02A5, 32'h0},         // launch 0xA5
      {2'd1, 8'h00, 32'h0,         32'h0000_0000}, // R3 ready dropped
      {2'd0, 8'h00, 32'h0000_02FF, 32'h0},         // launch while busy
      {2'd1, 8'h00, 32'h0,         32'h0000_0000}, // R4
      {2'd3, 8'h00, 32'h0,         32'h0},
      {2'd1, 8'h00, 32'h0,         32'h0000_0200}, // R4 ready back
      {2'd2, 8'h00, 32'h0000_003C, 32'h0},
      {2'd1, 8'h00, 32'h0,         32'h0000_033C}, // R5
      {2'd0, 8'h00, 32'h0000_0000, 32'h0},
      {2'd1, 8'h00, 32'h0,         32'h0000_033C}, // R7
      {2'd0, 8'h00, 32'h0000_0100, 32'h0},
      {2'd1, 8'h00, 32'h0,         32'h0000_023C}, // R6 byte kept
      {2'd2, 8'h00, 32'h0000_0011, 32'h0},
      {2'd2, 8'h00, 32'h0000_0022, 32'h0},
      {2'd1, 8'h00, 32'h0,         32'h0000_0311}, // R8 old byte kept
      {2'd0, 8'h00, 32'h0000_0100, 32'h0},
      {2'd1, 8'h00, 32'h0,         32'h0000_0211}  // R6
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      @(negedge clk);
      rx_strobe = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_strobe = 1'b0;
   endtask

   task automatic tx_pulse();
      @(negedge clk);
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      bus_read(5'h00, rd); check("R2 data", rd, 32'h200);
      bus_read(5'h04, rd); check("R2 ctrl", rd, 32'h0);
      bus_read(5'h08, rd); check("R2 clock", rd, 32'h0);
      check("R2 overrun", {31'b0, rx_overrun}, 32'h0);
      check("R2 tx_load", {31'b0, tx_load}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  k;
         logic [4:0]  a;
         logic [31:0] d, e;
         k = VEC[i][73:72]; a = VEC[i][68:64]; d = VEC[i][63:32]; e = VEC[i][31:0];
         case (k)
            2'd0: bus_write(a, d);
            2'd1: begin
               bus_read(a, rd);
               check($sformatf("table row %0d", i), rd, e);
            end
            2'd2: rx_push(d[7:0]);
            default: tx_pulse();
         endcase
      end

      // R3 exactly one load, with the launched byte
      check("R3 load count", loads, 32'd1);
      check("R3 load byte", {24'b0, last_load}, 32'hA5);
      // R9 / R10 outputs
      check("R9 mode/forces", {28'b0, if_mode, tx_force, rx_force}, 32'hF);
      check("R10 scale/step", {4'b0, baud_scale, baud_step}, 32'h0FFF_FFFF);

      // R8 overrun raised, R7 flagless write leaves it
      rx_push(8'h55);
      rx_push(8'h66);
      check("R8 overrun set", {31'b0, rx_overrun}, 32'h1);
      bus_write(5'h00, 32'h0000_0000);
      check("R7 overrun held", {31'b0, rx_overrun}, 32'h1);
      bus_read(5'h00, rd); check("R8 first byte kept", rd, 32'h355);

      // R8 acknowledge and new byte in the same cycle
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h100;
      rx_strobe = 1'b1; rx_byte = 8'h77;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; rx_strobe = 1'b0;
      check("R8 overrun cleared", {31'b0, rx_overrun}, 32'h0);
      bus_read(5'h00, rd); check("R8 new byte valid", rd, 32'h377);

      // R5 then R6 again, no loads triggered by receive traffic
      bus_write(5'h00, 32'h0000_0100);
      bus_read(5'h00, rd); check("R6 valid cleared", rd, 32'h277);
      check("R3 no extra loads", loads, 32'd1);

      done = 1'b1;
      summary();
   end
endmodule